// File: doc/BRIEF.md
# Serial Memory Status Register and Write Guard

This block keeps the status byte of a serial memory slave and rules on every write the SPI engine wants to perform. The engine hands it decoded one-cycle events (set-enable, clear-enable, status write with its data byte, and end of a memory write transaction), together with the hardware protect pin, a busy flag from the store/recall sequencer and the address of the pending memory write. In return the block presents the status byte the engine shifts out on a status read, and two permits: one for memory array writes and one for status writes.

The status byte holds a write-enable latch, a two-bit protected-range code, a protect-pin enable flag and a live ready bit. Memory writes need the latch set, no busy condition and an address outside the protected range. Status writes need the latch set, no busy condition, and must not meet the protect pin driven low while the protect-pin enable flag is set. The latch drops by itself once a status write or memory write transaction completes, so each write needs its own set-enable beforehand.

Top module: `nvs_status_protect`

## Requirements
- R1: After reset the write-enable latch, the range code and the protect-pin enable flag are all 0, so with busy low `status_byte` reads 0x00 and both permits are low.
- R2: A set-enable event sets bit 1 (write-enable) of `status_byte` in the following cycle. A clear-enable event clears it in the following cycle. Both act whether or not busy is high.
- R3: A status write event or an end-of-write event clears the write-enable bit in the following cycle, whether or not the status write was accepted. Any clear cause in the same cycle as a set-enable event wins.
- R4: Bit 0 (ready) of `status_byte` equals the `busy` input in the same cycle: 1 means a store or recall is running.
- R5: An accepted status write loads data bit 7 into status bit 7 (protect-pin enable) and data bits 3:2 into status bits 3:2 (range code). Status bits 6:4 always read 0. Data bits 6:4 and 1:0 have no effect.
- R6: `sr_wr_ok` is 1 exactly when write-enable is 1, busy is 0, and the pair of `wp_n` = 0 with status bit 7 = 1 is absent. A status write event while `sr_wr_ok` is 0 leaves status bits 7:2 unchanged.
- R7: Range codes in status bits 3:2 are: 00 protects nothing, 01 protects the top quarter (addresses 0xC000 to 0xFFFF), 10 protects the top half (0x8000 to 0xFFFF), and 11 protects every address. `mem_wr_ok` is 0 for a protected `wr_addr`.
- R8: `mem_wr_ok` is 1 only while write-enable is 1 and busy is 0. A status write event arriving while busy is high is refused.
- R9: The `wp_n` pin has no effect on `mem_wr_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_wren | input | 1 | One-cycle set-enable event |
| evt_wrdi | input | 1 | One-cycle clear-enable event |
| evt_wrsr | input | 1 | One-cycle completed status write event |
| wrsr_data | input | 8 | Data byte of the status write |
| evt_write_done | input | 1 | One-cycle end of a memory write transaction |
| wp_n | input | 1 | Hardware protect pin, active low |
| busy | input | 1 | Store or recall in progress |
| wr_addr | input | ADDR_W | Address of the pending memory write |
| status_byte | output | 8 | Status byte for a status read |
| mem_wr_ok | output | 1 | Memory array write permitted |
| sr_wr_ok | output | 1 | Status write permitted |

## Verification
A latch stuck set or clear shows up in bit 1 of the status byte one cycle after the event meant to change it. The same fault also flips `mem_wr_ok` and `sr_wr_ok` at once. A corrupted range code or protect-pin flag is visible in bits 7:2 from the cycle after the status write that loaded it. A wrong range decode shows only at the permit, for the same cycle, when `wr_addr` sits on either side of a quarter or half boundary. For that reason the addresses used are the last address below each boundary and the first address at it.

// File: rtl/nvs_status_pkg.sv
package nvs_status_pkg;

  // bit positions within the status byte
  localparam int unsigned RDY_BIT  = 0;
  localparam int unsigned WEN_BIT  = 1;
  localparam int unsigned BP_LSB   = 2;
  localparam int unsigned BP_MSB   = 3;
  localparam int unsigned WPEN_BIT = 7;
  localparam int unsigned BP_W     = BP_MSB - BP_LSB + 1;

  typedef enum logic [BP_W-1:0] {
    RANGE_NONE = 2'b00,
    RANGE_QTR  = 2'b01,
    RANGE_HALF = 2'b10,
    RANGE_ALL  = 2'b11
  } range_code_t;

endpackage

// File: rtl/nvs_rst_sync.sv
module nvs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/nvs_wel.sv
module nvs_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wen_o
);

  logic wen_q;
  logic wen_d;
  logic wen_ce;

  // clearing has priority over setting
  always_comb begin
    wen_ce = set_i | clr_i;
    wen_d  = ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q <= 1'b0;
    end else if (wen_ce) begin
      wen_q <= wen_d;
    end
  end

  assign wen_o = wen_q;

endmodule

// File: rtl/nvs_sr_fields.sv
module nvs_sr_fields
  import nvs_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [7:0]        data_i,
  output range_code_t       range_o,
  output logic              wpen_o
);

  range_code_t range_q;
  range_code_t range_d;
  logic        wpen_q;
  logic        wpen_d;

  always_comb begin
    range_d = range_code_t'(data_i[BP_MSB:BP_LSB]);
    wpen_d  = data_i[WPEN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      range_q <= RANGE_NONE;
      wpen_q  <= 1'b0;
    end else if (load_i) begin
      range_q <= range_d;
      wpen_q  <= wpen_d;
    end
  end

  assign range_o = range_q;
  assign wpen_o  = wpen_q;

endmodule

// File: rtl/nvs_range_guard.sv
module nvs_range_guard
  import nvs_status_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  range_code_t        range_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               locked_o
);

  localparam int unsigned TOP = ADDR_W - 1;

  logic in_top_half;
  logic in_top_qtr;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign in_top_half = addr_i[TOP];
      assign in_top_qtr  = addr_i[TOP] & addr_i[TOP-1];
    end else begin : g_narrow
      assign in_top_half = addr_i[TOP];
      assign in_top_qtr  = addr_i[TOP];
    end
  endgenerate

  always_comb begin
    unique case (range_i)
      RANGE_NONE: locked_o = 1'b0;
      RANGE_QTR:  locked_o = in_top_qtr;
      RANGE_HALF: locked_o = in_top_half;
      default:    locked_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/nvs_status_protect.sv
module nvs_status_protect
  import nvs_status_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_wren,
  input  logic              evt_wrdi,
  input  logic              evt_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic              evt_write_done,
  input  logic              wp_n,
  input  logic              busy,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        status_byte,
  output logic              mem_wr_ok,
  output logic              sr_wr_ok
);

  logic        rst_n_int;
  logic        wen;
  logic        wen_clr;
  logic        sr_load;
  logic        pin_lock;
  logic        addr_lock;
  logic        wpen;
  range_code_t range_code;

  nvs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  always_comb begin
    wen_clr  = evt_wrdi | evt_wrsr | evt_write_done;
    pin_lock = wpen & ~wp_n;
    sr_wr_ok = wen & ~busy & ~pin_lock;
    sr_load  = evt_wrsr & sr_wr_ok;
    mem_wr_ok = wen & ~busy & ~addr_lock;
  end

  nvs_wel u_wel (
    .clk   (clk),
    .rst_n (rst_n_int),
    .set_i (evt_wren),
    .clr_i (wen_clr),
    .wen_o (wen)
  );

  nvs_sr_fields u_fields (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load_i  (sr_load),
    .data_i  (wrsr_data),
    .range_o (range_code),
    .wpen_o  (wpen)
  );

  nvs_range_guard #(.ADDR_W(ADDR_W)) u_guard (
    .range_i  (range_code),
    .addr_i   (wr_addr),
    .locked_o (addr_lock)
  );

  always_comb begin
    status_byte                = '0;
    status_byte[RDY_BIT]       = busy;
    status_byte[WEN_BIT]       = wen;
    status_byte[BP_MSB:BP_LSB] = range_code;
    status_byte[WPEN_BIT]      = wpen;
  end

endmodule

// File: rtl/nvs_status_protect_chk.sv
module nvs_status_protect_chk #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_wren,
  input logic              evt_wrdi,
  input logic              evt_wrsr,
  input logic [7:0]        wrsr_data,
  input logic              evt_write_done,
  input logic              wp_n,
  input logic              busy,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        status_byte,
  input logic              mem_wr_ok,
  input logic              sr_wr_ok
);

  logic any_clr;
  assign any_clr = evt_wrdi | evt_wrsr | evt_write_done;

  p_wen_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wren && !any_clr) |=> status_byte[1]);

  p_wen_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    any_clr |=> !status_byte[1]);

  p_rdy_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[0] == busy);

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wrsr && sr_wr_ok) |=>
      (status_byte[7] == $past(wrsr_data[7])) && (status_byte[3:2] == $past(wrsr_data[3:2])));

  p_unused_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[6:4] == 3'b000);

  p_refused_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wrsr && !sr_wr_ok) |=> $stable(status_byte[7:2]));

  p_pin_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_ok |-> (status_byte[1] && !busy && !(status_byte[7] && !wp_n)));

  p_full_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[3:2] == 2'b11) |-> !mem_wr_ok);

  p_mem_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_ok |-> (status_byte[1] && !busy));

endmodule

bind nvs_status_protect nvs_status_protect_chk #(
  .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/tb_nvs_status_protect.sv
`timescale 1ns/1ps
module tb_nvs_status_protect;

  logic        clk;
  logic        rst_n;
  logic        evt_wren, evt_wrdi, evt_wrsr, evt_write_done;
  logic [7:0]  wrsr_data;
  logic        wp_n, busy;
  logic [15:0] wr_addr;
  logic [7:0]  status_byte;
  logic        mem_wr_ok, sr_wr_ok;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  typedef struct {
    logic [7:0] st;
    logic       mem;
    logic       sr;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  // bench model of the register contents
  logic       m_wen;
  logic [1:0] m_bp;
  logic       m_wpen;

  nvs_status_protect dut (
    .clk(clk), .rst_n(rst_n),
    .evt_wren(evt_wren), .evt_wrdi(evt_wrdi), .evt_wrsr(evt_wrsr),
    .wrsr_data(wrsr_data), .evt_write_done(evt_write_done),
    .wp_n(wp_n), .busy(busy), .wr_addr(wr_addr),
    .status_byte(status_byte), .mem_wr_ok(mem_wr_ok), .sr_wr_ok(sr_wr_ok)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic locked(input logic [1:0] bp, input logic [15:0] a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a >= 16'hC000;
      2'b10:   return a >= 16'h8000;
      default: return 1'b1;
    endcase
  endfunction

  task automatic push_expect(input string tag);
    exp_t e;
    e.st  = {m_wpen, 3'b000, m_bp, m_wen, busy};
    e.sr  = m_wen && !busy && !(m_wpen && !wp_n);
    e.mem = m_wen && !busy && !locked(m_bp, wr_addr);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic step(input logic wren, input logic wrdi, input logic wrsr,
                      input logic wdone, input logic [7:0] d, input logic wp,
                      input logic bsy, input logic [15:0] addr, input string tag);
    @(posedge clk); #4;
    evt_wren = wren; evt_wrdi = wrdi; evt_wrsr = wrsr; evt_write_done = wdone;
    wrsr_data = d; wp_n = wp; busy = bsy; wr_addr = addr;
    if (wrsr && m_wen && !bsy && !(m_wpen && !wp)) begin
      m_bp   = d[3:2];
      m_wpen = d[7];
    end
    if (wrdi || wrsr || wdone) m_wen = 1'b0;
    else if (wren)             m_wen = 1'b1;
    @(posedge clk); #4;
    evt_wren = 0; evt_wrdi = 0; evt_wrsr = 0; evt_write_done = 0;
    push_expect(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (status_byte !== e.st || mem_wr_ok !== e.mem || sr_wr_ok !== e.sr) begin
        errors++;
        $display("FAIL %s: actual st=%02h mem=%0b sr=%0b expected st=%02h mem=%0b sr=%0b",
                 e.tag, status_byte, mem_wr_ok, sr_wr_ok, e.st, e.mem, e.sr);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; evt_wren = 0; evt_wrdi = 0; evt_wrsr = 0; evt_write_done = 0;
    wrsr_data = 0; wp_n = 1; busy = 0; wr_addr = 0;
    m_wen = 0; m_bp = 0; m_wpen = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R1 during reset
    if (status_byte !== 8'h00 || mem_wr_ok !== 1'b0 || sr_wr_ok !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: actual st=%02h mem=%0b sr=%0b expected st=00 mem=0 sr=0",
               status_byte, mem_wr_ok, sr_wr_ok);
    end
    rst_n = 1;
    repeat (4) @(posedge clk);

    step(0,0,0,0,8'h00,1,0,16'h0000, "R1 idle after reset");
    step(1,0,0,0,8'h00,1,0,16'h0000, "R2 set-enable");
    step(0,1,0,0,8'h00,1,0,16'h0000, "R2 clear-enable");
    step(1,0,0,1,8'h00,1,0,16'h0000, "R3 clear beats set");
    step(1,0,0,0,8'h00,1,0,16'h0000, "R2 set again");
    step(0,0,0,1,8'h00,1,0,16'h0000, "R3 end-of-write clears");
    step(1,0,0,0,8'h00,1,0,16'h0000, "R2 set before status write");
    step(0,0,1,0,8'hF7,1,0,16'h0000, "R5 status load ignores bits 6:4 1:0");
    step(1,0,0,0,8'h00,1,0,16'hBFFF, "R7 quarter below boundary");
    step(0,0,0,0,8'h00,1,0,16'hC000, "R7 quarter at boundary");
    step(0,0,0,0,8'h00,0,0,16'h0000, "R9 pin low leaves memory permit");
    step(0,0,0,0,8'h00,0,0,16'hC000, "R6 pin lock blocks status permit");
    step(0,0,1,0,8'h08,0,0,16'h0000, "R6 refused status write keeps fields");
    step(1,0,0,0,8'h00,1,0,16'h0000, "R2 set with pin high");
    step(0,0,1,0,8'h08,1,0,16'h7FFF, "R5 load half code");
    step(1,0,0,0,8'h00,1,0,16'h7FFF, "R7 half below boundary");
    step(0,0,0,0,8'h00,1,0,16'h8000, "R7 half at boundary");
    step(0,0,1,0,8'h0C,1,0,16'h0000, "R5 load full code");
    step(1,0,0,0,8'h00,1,0,16'h0000, "R7 full array locked");
    step(0,0,0,0,8'h00,1,1,16'h0000, "R4 ready follows busy");
    step(0,0,1,0,8'h00,1,1,16'h0000, "R8 status write refused while busy");
    step(1,0,0,0,8'h00,1,1,16'h0000, "R8 enable set but busy blocks");
    step(0,0,0,0,8'h00,1,0,16'h0000, "R4 ready drops with busy");
    step(0,0,1,0,8'h00,1,0,16'h0000, "R5 clear fields");
    step(1,0,0,0,8'h00,0,0,16'hFFFF, "R9 pin low without enable flag");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule